// File: doc/BRIEF.md
# Serial Audio Clock and Frame Engine

This block is the digital audio port of a stereo codec that acts as clock master. It runs on a master clock at 256 times the sample rate and derives two clocks from it: a bit clock at one eighth of the master rate and a frame clock that selects the left or right channel. Each frame it shifts one 16-bit left word and one 16-bit right word out on a serial line and shifts two such words in from a serial line. Both directions send the most significant bit first, in two's complement. There is no one-bit delay between a frame clock edge and the first bit of a slot.

On the parallel side, outgoing words use a valid/ready handshake. `tx_ready` is high for exactly one master clock per frame. A word pair moves into the block when `tx_valid` and `tx_ready` are both high on the same edge. The serial timing is fixed and cannot wait, so the block never stalls. If `tx_valid` is low while `tx_ready` is high, that frame is sent as all zeros. The receive side gives no back-pressure either. `rx_valid` is a single-cycle strobe, and the consumer must take the word pair before the next strobe, which comes 256 master clocks later and overwrites the pair.

The active-low reset also acts as power-down. While it is held low, every output is held at zero and the clocks stop.

Top module: `serial_audio_master`

## Requirements
- R1: `bclk` has a period of exactly 8 `mclk` cycles. It is low for 4 cycles and then high for 4 cycles.
- R2: `lrclk` is low for 16 `bclk` periods (left slot) and then high for 16 (right slot), giving a 256-cycle frame. It changes only in the cycle in which `bclk` falls.
- R3: `sdo` changes only in a cycle in which `bclk` falls. Bits sent in a frame: left bit 15 down to bit 0, then right bit 15 down to bit 0. One bit is sent per `bclk` period, starting at the `lrclk` falling edge.
- R4: `sdi` is sampled on each `bclk` rising edge. Within a frame, the first 16 samples form the left word and the last 16 form the right word, most significant bit first.
- R5: `rx_valid` is high for exactly one `mclk` cycle per frame, in the cycle after the `bclk` rise that captured the last right bit. `rx_left` and `rx_right` hold the captured words until the next strobe.
- R6: `tx_ready` is high for exactly one `mclk` cycle per frame, in the last cycle of the frame. When `tx_valid` is high at that edge, `tx_left` and `tx_right` are sent in the next frame. When `tx_valid` is low, the next frame sends zeros. Word inputs at any other cycle are ignored.
- R7: While `rst_n` is low, `bclk`, `lrclk`, `sdo`, `tx_ready`, `rx_valid`, `rx_left` and `rx_right` are all 0.
- R8: After `rst_n` is released, the first `bclk` rise comes on the 4th `mclk` edge. The first frame starts in the left slot and sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset and power-down |
| tx_valid | input | 1 | Outgoing word pair is valid |
| tx_ready | output | 1 | Block takes the outgoing pair on this edge |
| tx_left | input | 16 | Outgoing left sample |
| tx_right | input | 16 | Outgoing right sample |
| sdi | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle strobe: a new received pair is available |
| rx_left | output | 16 | Last received left sample |
| rx_right | output | 16 | Last received right sample |
| bclk | output | 1 | Bit clock, master clock divided by 8 |
| lrclk | output | 1 | Frame clock: low for left, high for right |
| sdo | output | 1 | Serial data out |

## Verification
The serial input is driven from random word pairs mixed with sign-boundary pairs such as 0x8000/0x7FFF and 0xFFFF/0x0001. These show whether the left and right words are swapped, the bit order is reversed, or the capture is shifted by one position. The outgoing side receives random data on every cycle, with `tx_valid` sometimes low and forced low on one frame. This separates a correct one-cycle handshake from a design that latches on the wrong cycle or sends stale data on underrun. A reset in the middle of the run checks that the outputs are held at zero and that the first frame after release is all zeros and starts on time.

// File: rtl/sam_pkg.sv
package sam_pkg;
  // sample width and master-to-bit clock ratio
  localparam int SAMPLE_W  = 16;
  localparam int BCLK_DIV  = 8;
  localparam int DIV_W     = $clog2(BCLK_DIV);
  localparam int SLOT_W    = $clog2(2 * SAMPLE_W);
  localparam int FRAME_CW  = DIV_W + SLOT_W;
endpackage

// File: rtl/sam_clkgen.sv
module sam_clkgen #(
  parameter int DIV_W  = 3,
  parameter int SLOT_W = 5
) (
  input  logic mclk,
  input  logic rst_n,
  output logic bclk,
  output logic lrclk,
  output logic rise_stb,   // next edge raises bclk
  output logic fall_stb,   // next edge lowers bclk
  output logic frame_end,  // last mclk of the frame
  output logic last_rise   // rise that samples final right bit
);
  localparam int CW = DIV_W + SLOT_W;
  localparam logic [DIV_W-1:0] HALF_M1 = DIV_W'((1 << (DIV_W - 1)) - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign bclk      = cnt_q[DIV_W-1];
  assign lrclk     = cnt_q[CW-1];
  assign rise_stb  = (cnt_q[DIV_W-1:0] == HALF_M1);
  assign fall_stb  = &cnt_q[DIV_W-1:0];
  assign frame_end = &cnt_q;
  assign last_rise = rise_stb && (&cnt_q[CW-1:DIV_W]);

  // R2
  lr_on_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(lrclk) |-> $fell(bclk));
  // R1
  bclk_fall_after_high_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $fell(bclk) |-> $past(bclk, 1) && $past(fall_stb, 1));
endmodule

// File: rtl/sam_tx.sv
module sam_tx #(
  parameter int SAMPLE_W = 16
) (
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fall_stb,
  input  logic                frame_end,
  input  logic                tx_valid,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                tx_ready,
  output logic                sdo
);
  localparam int FW = 2 * SAMPLE_W;

  logic [FW-1:0] sh_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '0;
    else if (frame_end)
      sh_q <= tx_valid ? {tx_left, tx_right} : '0;
    else if (fall_stb)
      sh_q <= {sh_q[FW-2:0], 1'b0};
  end

  assign tx_ready = frame_end;
  assign sdo      = sh_q[FW-1];

  // R3
  sdo_on_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(sdo) |-> $fell(bclk));
  // R6
  ready_single_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
endmodule

// File: rtl/sam_rx.sv
module sam_rx #(
  parameter int SAMPLE_W = 16
) (
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                rise_stb,
  input  logic                last_rise,
  input  logic                sdi,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right
);
  localparam int FW = 2 * SAMPLE_W;

  logic [FW-1:0] sh_q;
  logic [FW-1:0] nxt;

  assign nxt = {sh_q[FW-2:0], sdi};

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_valid <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
    end else begin
      rx_valid <= last_rise;
      if (rise_stb) sh_q <= nxt;
      if (last_rise) begin
        rx_left  <= nxt[FW-1:SAMPLE_W];
        rx_right <= nxt[SAMPLE_W-1:0];
      end
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  valid_in_right_slot_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    rx_valid |-> (lrclk && bclk));
  // R5
  words_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_left) && $stable(rx_right));
endmodule

// File: rtl/serial_audio_master.sv
module serial_audio_master
  import sam_pkg::*;
(
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  input  logic                sdi,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdo
);
  logic rise_stb, fall_stb, frame_end, last_rise;

  sam_clkgen #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_clkgen (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .lrclk     (lrclk),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .frame_end (frame_end),
    .last_rise (last_rise)
  );

  sam_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .fall_stb  (fall_stb),
    .frame_end (frame_end),
    .tx_valid  (tx_valid),
    .tx_left   (tx_left),
    .tx_right  (tx_right),
    .tx_ready  (tx_ready),
    .sdo       (sdo)
  );

  sam_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .lrclk     (lrclk),
    .rise_stb  (rise_stb),
    .last_rise (last_rise),
    .sdi       (sdi),
    .rx_valid  (rx_valid),
    .rx_left   (rx_left),
    .rx_right  (rx_right)
  );

  // R6
  ready_at_frame_tail_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    tx_ready |=> $fell(lrclk));
endmodule

// File: tb/serial_audio_master_tb.sv
module serial_audio_master_tb;
  logic        mclk = 1'b0;
  logic        rst_n;
  logic        tx_valid;
  logic        tx_ready;
  logic [15:0] tx_left, tx_right;
  logic        sdi;
  logic        rx_valid;
  logic [15:0] rx_left, rx_right;
  logic        bclk, lrclk, sdo;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 mclk = ~mclk;

  serial_audio_master u_dut (
    .mclk(mclk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_left(tx_left), .tx_right(tx_right), .sdi(sdi), .rx_valid(rx_valid),
    .rx_left(rx_left), .rx_right(rx_right), .bclk(bclk), .lrclk(lrclk), .sdo(sdo)
  );

  // bench model state
  logic [31:0] in_frame;   // pair being driven on sdi
  int          in_bit;
  int          in_frames;
  logic [31:0] exp_out;    // pair expected on sdo this frame
  logic [31:0] got_out;
  int          rises;
  int          tx_frames;
  int          cyc_since_rise;
  int          cyc_since_rst;
  int          cyc_since_valid;
  bit          seen_rise, seen_valid;
  logic        p_bclk, p_lr, p_sdo;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rx_pattern(input int n);
    case (n)
      0: rx_pattern = 32'h8000_7FFF;
      1: rx_pattern = 32'hFFFF_0001;
      2: rx_pattern = 32'h0001_8000;
      default: rx_pattern = $urandom;
    endcase
  endfunction

  task automatic restart_model();
    in_frames = 0;
    in_frame  = rx_pattern(0);
    in_bit    = 0;
    sdi       = in_frame[31];
    exp_out   = 32'h0;      // R8: first frame is zeros
    got_out   = 32'h0;
    rises     = 0;
    tx_frames = 0;
    seen_rise = 0;
    seen_valid = 0;
    cyc_since_rst = 0;
    p_bclk = 1'b0; p_lr = 1'b0; p_sdo = 1'b0;
  endtask

  task automatic check_reset_state();
    chk(bclk == 1'b0,     "R7", "bclk in reset", {31'b0, bclk}, 32'h0);
    chk(lrclk == 1'b0,    "R7", "lrclk in reset", {31'b0, lrclk}, 32'h0);
    chk(sdo == 1'b0,      "R7", "sdo in reset", {31'b0, sdo}, 32'h0);
    chk(tx_ready == 1'b0, "R7", "tx_ready in reset", {31'b0, tx_ready}, 32'h0);
    chk(rx_valid == 1'b0, "R7", "rx_valid in reset", {31'b0, rx_valid}, 32'h0);
    chk({rx_left, rx_right} == 32'h0, "R7", "rx words in reset",
        {rx_left, rx_right}, 32'h0);
  endtask

  // observe outputs at the negative edge, then drive the next inputs
  task automatic step();
    bit rose, fell;
    @(negedge mclk);
    cyc_since_rst++;
    cyc_since_rise++;
    cyc_since_valid++;
    rose = (p_bclk == 1'b0) && (bclk == 1'b1);
    fell = (p_bclk == 1'b1) && (bclk == 1'b0);

    if (lrclk !== p_lr)
      chk(fell, "R2", "lrclk changed without bclk fall", {31'b0, lrclk}, {31'b0, p_lr});
    if (sdo !== p_sdo)
      chk(fell, "R3", "sdo changed without bclk fall", {31'b0, sdo}, {31'b0, p_sdo});

    if (fell)
      chk(cyc_since_rise == 4, "R1", "bclk high time", cyc_since_rise, 4);

    if (rx_valid) begin
      chk({rx_left, rx_right} == in_frame, "R4", "received pair",
          {rx_left, rx_right}, in_frame);
      chk(lrclk == 1'b1 && rises == 31 && cyc_since_rise == 8, "R5", "strobe position",
          {16'(rises), 16'(cyc_since_rise)}, {16'd31, 16'd8});
      if (seen_valid)
        chk(cyc_since_valid == 256, "R5", "strobe interval", cyc_since_valid, 256);
      seen_valid = 1;
      cyc_since_valid = 0;
    end

    if (rose) begin
      if (!seen_rise)
        chk(cyc_since_rst == 4, "R8", "first bclk rise", cyc_since_rst, 4);
      else
        chk(cyc_since_rise == 8, "R1", "bclk period", cyc_since_rise, 8);
      seen_rise = 1;
      cyc_since_rise = 0;
      chk(lrclk == (rises >= 16), "R2", "lrclk slot", {31'b0, lrclk},
          {31'b0, (rises >= 16)});
      got_out = {got_out[30:0], sdo};
      rises++;
      if (rises == 32) begin
        chk(got_out == exp_out, (tx_frames == 0) ? "R8" : "R3", "serial out frame",
            got_out, exp_out);
        rises = 0;
      end
    end

    if (fell) begin
      in_bit++;
      if (in_bit == 32) begin
        in_bit = 0;
        in_frames++;
        in_frame = rx_pattern(in_frames);
      end
      sdi = in_frame[31 - in_bit];
    end

    // new words every cycle; only the ready cycle may matter (R6)
    tx_left  = 16'($urandom);
    tx_right = 16'($urandom);
    tx_valid = 1'($urandom);
    if (tx_ready) begin
      tx_frames++;
      if (tx_frames == 1) tx_valid = 1'b0;
      else if (tx_frames == 2) begin
        tx_valid = 1'b1; tx_left = 16'h8000; tx_right = 16'h7FFF;
      end else if (tx_frames == 3) begin
        tx_valid = 1'b1; tx_left = 16'hFFFF; tx_right = 16'h0001;
      end
      exp_out = tx_valid ? {tx_left, tx_right} : 32'h0;   // R6
    end

    p_bclk = bclk; p_lr = lrclk; p_sdo = sdo;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5A17);
    rst_n = 1'b0; tx_valid = 1'b0; tx_left = '0; tx_right = '0; sdi = 1'b0;
    repeat (5) @(negedge mclk);
    check_reset_state();
    restart_model();
    rst_n = 1'b1;
    for (int c = 0; c < 256 * 20; c++) step();

    // reset mid-run: outputs held at zero, then a clean restart
    @(negedge mclk);
    rst_n = 1'b0;
    repeat (3) @(negedge mclk);
    check_reset_state();
    repeat (30) @(negedge mclk);
    check_reset_state();
    restart_model();
    rst_n = 1'b1;
    for (int c = 0; c < 256 * 20; c++) step();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule